// File: doc/BRIEF.md
# Gap-free packet feeder with ready latency

This block feeds a MAC transmit port that takes 64-bit words and does not allow idle cycles inside a packet. Words arrive from a bursty producer with start, end, empty-byte count and error markers. There is no backpressure on the producer side. Each word goes into a word store, and a packet is launched on the output only after its end word has been stored. The whole packet is then already local, so valid stays high from the start word to the end word whatever the sink's ready does.

The sink accepts words under one of two rules, picked by `cfg_rdy_late`. With 0, a word is taken in the cycle where `out_ready` is high. With 1, a word is taken in a cycle where `out_ready` was high `LAT` cycles earlier (3 by default). In both modes a word that is not taken is held unchanged. `cfg_rdy_late` may only be changed while no packet is buffered or in flight. The producer must close each packet with an end word before it starts the next one.

Packets of one word are dropped. Such a packet carries at most 8 bytes, and with 8-byte words it is the only way a packet can fall below the 9-byte minimum. A start word that finds fewer than two free entries causes the whole packet to be discarded. If the store fills up in the middle of a packet, the packet is cut: the last word stored becomes its end word and carries the error flag. The words that follow are dropped until the next start.

Top module: `gapless_tx_feeder`

## Requirements
- R1: A packet appears on the output only after its end word has been stored. Its first output word has `out_sop` high. `out_valid` then stays high on every cycle until the cycle in which the end word is taken.
- R2: Output words carry the input data unchanged and in input order. Bit 63 holds the first byte of each word.
- R3: With `cfg_rdy_late`=0 a word is taken in a cycle where `out_ready` is high. With `cfg_rdy_late`=1 a word is taken in a cycle where `out_ready` was high `LAT` cycles before. While a word is not taken, data, start, end, empty and error are held.
- R4: A packet with start and end in the same input word is dropped and never appears on the output.
- R5: `out_empty` (3 bits, the count of unused low-order bytes) equals the input empty value of the end word. It is 0 on every word that is not an end word, whatever the producer drives there.
- R6: `out_err` is high only on an end word whose input error flag was high together with end. Error flags given on other words are ignored.
- R7: A start word that arrives with fewer than 2 free store entries causes the whole packet to be discarded.
- R8: A non-start word that arrives while the store holds `DEPTH` words cuts the open packet. The previously stored word becomes the end word, with error 1 and empty 0. Input is then dropped until the next start word.
- R9: Non-start words that arrive outside an open packet are ignored.
- R10: During reset and right after it, `out_valid`, `out_sop` and `out_eop` are low and the store is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rdy_late | input | 1 | 0: take on ready now; 1: take on ready LAT cycles ago |
| in_valid | input | 1 | Producer word present |
| in_sop | input | 1 | Producer word is a packet start |
| in_eop | input | 1 | Producer word is a packet end |
| in_empty | input | 3 | Unused bytes in the end word |
| in_err | input | 1 | Error mark, honoured only with in_eop |
| in_data | input | 64 | Producer word, first byte in bits 63:56 |
| out_ready | input | 1 | Sink can accept |
| out_valid | output | 1 | Output word present |
| out_sop | output | 1 | Output word is a packet start |
| out_eop | output | 1 | Output word is a packet end |
| out_empty | output | 3 | Unused bytes in the output end word |
| out_err | output | 1 | Output packet marked bad |
| out_data | output | 64 | Output word |

## Verification
A wrong packet count or read pointer shows up at the ports within one take. It appears either as a word that differs from the scoreboard's next expected word, or as `out_valid` dropping inside a packet in the very next cycle. A wrong ready delay line makes the block advance a cycle early or late against the bench's own three-deep history of `out_ready`. That is caught as a changed word that was not taken, or as a mismatch on the following take. A wrong fill count or a wrong flag rewrite after overflow shows up as soon as the stalled sink is released. The released packets then have the wrong length or the wrong end and error marks, or a packet that should have been dropped appears.

// File: rtl/gtf_pkg.sv
package gtf_pkg;

  typedef enum logic [1:0] {
    ADM_IDLE = 2'd0,
    ADM_PASS = 2'd1,
    ADM_DROP = 2'd2
  } adm_state_e;

  // Wrapping index step, valid for any depth.
  function automatic int next_index(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

  function automatic int prev_index(input int idx, input int depth);
    return (idx == 0) ? depth - 1 : idx - 1;
  endfunction

  // True when at least 'need' entries are free.
  function automatic logic has_room(input int fill, input int depth, input int need);
    return (depth - fill) >= need;
  endfunction

  // A single-word packet: start and end in the same word.
  function automatic logic one_word_pkt(input logic sop, input logic eop);
    return sop & eop;
  endfunction

  // The ready sample that governs a take in the selected mode.
  function automatic logic sink_takes(input logic late, input logic rdy_now, input logic rdy_old);
    return late ? rdy_old : rdy_now;
  endfunction

endpackage

// File: rtl/gtf_admit.sv
module gtf_admit
  import gtf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int EMPTY_W = $clog2(DATA_W/8),
  localparam int CNT_W   = $clog2(DEPTH+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               in_err,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [CNT_W-1:0]   fill,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data,
  output logic               wr_eop,
  output logic [EMPTY_W-1:0] wr_empty,
  output logic               wr_err,
  output logic               cut_en,
  output logic               pkt_closed,
  output logic               runt_drop,
  output logic               full_drop
);

  adm_state_e st, st_nx;

  always_comb begin
    st_nx     = st;
    wr_en     = 1'b0;
    cut_en    = 1'b0;
    runt_drop = 1'b0;
    full_drop = 1'b0;
    if (in_valid) begin
      if (in_sop) begin
        if (one_word_pkt(in_sop, in_eop)) begin
          runt_drop = 1'b1;
          st_nx     = ADM_IDLE;
        end else if (has_room(32'(fill), DEPTH, 2)) begin
          wr_en = 1'b1;
          st_nx = ADM_PASS;
        end else begin
          full_drop = 1'b1;
          st_nx     = ADM_DROP;
        end
      end else if (st == ADM_PASS) begin
        if (has_room(32'(fill), DEPTH, 1)) begin
          wr_en = 1'b1;
          if (in_eop) st_nx = ADM_IDLE;
        end else begin
          cut_en = 1'b1;
          st_nx  = in_eop ? ADM_IDLE : ADM_DROP;
        end
      end else if (st == ADM_DROP && in_eop) begin
        st_nx = ADM_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ADM_IDLE;
    else        st <= st_nx;
  end

  assign wr_data    = in_data;
  assign wr_eop     = in_eop;
  assign wr_empty   = in_eop ? in_empty : '0;
  assign wr_err     = in_eop & in_err;
  assign pkt_closed = (wr_en & in_eop) | cut_en;

endmodule

// File: rtl/gtf_store.sv
module gtf_store
  import gtf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int EMPTY_W = $clog2(DATA_W/8),
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_eop,
  input  logic [EMPTY_W-1:0] wr_empty,
  input  logic               wr_err,
  input  logic               cut_en,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  head_data,
  output logic               head_eop,
  output logic [EMPTY_W-1:0] head_empty,
  output logic               head_err,
  output logic [CNT_W-1:0]   fill
);

  logic [DATA_W-1:0]  data_q  [DEPTH];
  logic [EMPTY_W-1:0] empty_q [DEPTH];
  logic [DEPTH-1:0]   eop_q, err_q;
  logic [PTR_W-1:0]   wr_ptr, rd_ptr, last_ptr;

  assign last_ptr = PTR_W'(prev_index(32'(wr_ptr), DEPTH));

  // Payload and empty count: no reset needed, read only after written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_q[wr_ptr]  <= wr_data;
      empty_q[wr_ptr] <= wr_empty;
    end
    if (cut_en) empty_q[last_ptr] <= '0;
  end

  // End and error marks; a cut rewrites the newest stored word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eop_q <= '0;
      err_q <= '0;
    end else begin
      if (wr_en) begin
        eop_q[wr_ptr] <= wr_eop;
        err_q[wr_ptr] <= wr_err;
      end
      if (cut_en) begin
        eop_q[last_ptr] <= 1'b1;
        err_q[last_ptr] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (wr_en) wr_ptr <= PTR_W'(next_index(32'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= PTR_W'(next_index(32'(rd_ptr), DEPTH));
      fill <= fill + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

  assign head_data  = data_q[rd_ptr];
  assign head_empty = empty_q[rd_ptr];
  assign head_eop   = eop_q[rd_ptr];
  assign head_err   = err_q[rd_ptr];

endmodule

// File: rtl/gtf_outseq.sv
module gtf_outseq
  import gtf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int LAT    = 3,
  localparam int EMPTY_W = $clog2(DATA_W/8),
  localparam int CNT_W   = $clog2(DEPTH+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_rdy_late,
  input  logic               out_ready,
  input  logic               pkt_closed,
  input  logic [DATA_W-1:0]  head_data,
  input  logic               head_eop,
  input  logic [EMPTY_W-1:0] head_empty,
  input  logic               head_err,
  output logic               take,
  output logic               launch,
  output logic [CNT_W-1:0]   pkt_cnt,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic               out_err,
  output logic [DATA_W-1:0]  out_data
);

  logic [LAT-1:0] rdy_pipe;
  logic           active, first, last_take;

  // Delay line for the ready input; the variant depends on LAT.
  generate
    if (LAT == 1) begin : g_pipe1
      always_ff @(posedge clk) begin
        if (!rst_n) rdy_pipe <= '0;
        else        rdy_pipe <= out_ready;
      end
    end else begin : g_pipeN
      always_ff @(posedge clk) begin
        if (!rst_n) rdy_pipe <= '0;
        else        rdy_pipe <= {rdy_pipe[LAT-2:0], out_ready};
      end
    end
  endgenerate

  assign take      = active & sink_takes(cfg_rdy_late, out_ready, rdy_pipe[LAT-1]);
  assign last_take = take & head_eop;
  assign launch    = ~active & (pkt_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      first   <= 1'b0;
      pkt_cnt <= '0;
    end else begin
      if (launch)         active <= 1'b1;
      else if (last_take) active <= 1'b0;
      if (launch)    first <= 1'b1;
      else if (take) first <= 1'b0;
      pkt_cnt <= pkt_cnt + CNT_W'(pkt_closed) - CNT_W'(last_take);
    end
  end

  assign out_valid = active;
  assign out_sop   = active & first;
  assign out_eop   = active & head_eop;
  assign out_empty = (active & head_eop) ? head_empty : '0;
  assign out_err   = active & head_eop & head_err;
  assign out_data  = active ? head_data : '0;

endmodule

// File: rtl/gapless_tx_feeder.sv
module gapless_tx_feeder #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int LAT    = 3,
  localparam int EMPTY_W = $clog2(DATA_W/8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_rdy_late,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               in_err,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               out_ready,
  output logic               out_valid,
  output logic               out_sop,
  output logic               out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic               out_err,
  output logic [DATA_W-1:0]  out_data
);

  localparam int CNT_W = $clog2(DEPTH+1);

  // Named internal events, also seen by the bound checker.
  logic               wr_en, wr_eop, wr_err, cut_en, pkt_closed;
  logic               runt_drop, full_drop, take, launch;
  logic [DATA_W-1:0]  wr_data, head_data;
  logic [EMPTY_W-1:0] wr_empty, head_empty;
  logic               head_eop, head_err;
  logic [CNT_W-1:0]   fill, pkt_cnt;

  gtf_admit #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_admit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .in_err(in_err), .in_data(in_data),
    .fill(fill),
    .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .wr_empty(wr_empty), .wr_err(wr_err),
    .cut_en(cut_en), .pkt_closed(pkt_closed),
    .runt_drop(runt_drop), .full_drop(full_drop)
  );

  gtf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .wr_empty(wr_empty), .wr_err(wr_err),
    .cut_en(cut_en), .rd_en(take),
    .head_data(head_data), .head_eop(head_eop),
    .head_empty(head_empty), .head_err(head_err),
    .fill(fill)
  );

  gtf_outseq #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)) u_outseq (
    .clk(clk), .rst_n(rst_n),
    .cfg_rdy_late(cfg_rdy_late), .out_ready(out_ready),
    .pkt_closed(pkt_closed),
    .head_data(head_data), .head_eop(head_eop),
    .head_empty(head_empty), .head_err(head_err),
    .take(take), .launch(launch), .pkt_cnt(pkt_cnt),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_empty(out_empty), .out_err(out_err), .out_data(out_data)
  );

endmodule

// File: rtl/gapless_tx_feeder_chk.sv
module gapless_tx_feeder_chk #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  parameter int LAT    = 3,
  localparam int EMPTY_W = $clog2(DATA_W/8),
  localparam int CNT_W   = $clog2(DEPTH+1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_rdy_late,
  input logic               out_ready,
  input logic               out_valid,
  input logic               out_sop,
  input logic               out_eop,
  input logic [EMPTY_W-1:0] out_empty,
  input logic               out_err,
  input logic [DATA_W-1:0]  out_data,
  input logic               take,
  input logic               launch,
  input logic [CNT_W-1:0]   pkt_cnt,
  input logic [CNT_W-1:0]   fill,
  input logic               wr_en,
  input logic               runt_drop,
  input logic               cut_en
);

  // R1: no hole inside a packet
  a_r1_valid_gapfree: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(take && out_eop) |=> out_valid);

  // R1: a packet on the output is a counted, complete packet
  a_r1_counted: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pkt_cnt != '0);

  // R1: a launch makes the start word appear next cycle
  a_r1_launch_sop: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> out_valid && out_sop);

  // R3: untaken word is held
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !take |=> $stable(out_data) && $stable(out_sop) && $stable(out_eop)
                          && $stable(out_empty) && $stable(out_err));

  // R3: same-cycle mode takes only with ready high
  a_r3_take_now: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdy_late && take |-> out_ready);

  // R3: delayed mode takes only with ready high three cycles earlier
  a_r3_take_late: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdy_late && take |-> $past(out_ready, 3));

  // R4: never a start and end on the same output word
  a_r4_no_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> !out_eop);

  // R4: a dropped single-word packet does not grow the store
  a_r4_runt_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    runt_drop |=> fill <= $past(fill));

  // R5, R6: non-end words carry zero empty and no error
  a_r5_mid_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_empty == '0 && !out_err);

  // R8: writes only into a free entry, cuts only when full
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> fill < CNT_W'(DEPTH));

  a_r8_cut_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    cut_en |-> fill == CNT_W'(DEPTH));

endmodule

bind gapless_tx_feeder gapless_tx_feeder_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdy_late(cfg_rdy_late), .out_ready(out_ready),
  .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
  .out_empty(out_empty), .out_err(out_err), .out_data(out_data),
  .take(take), .launch(launch), .pkt_cnt(pkt_cnt), .fill(fill),
  .wr_en(wr_en), .runt_drop(runt_drop), .cut_en(cut_en)
);

// File: tb/test_gapless_tx_feeder.sv
module test_gapless_tx_feeder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rdy_late = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [2:0]  in_empty = '0;
  logic [63:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, out_sop, out_eop, out_err;
  logic [2:0]  out_empty;
  logic [63:0] out_data;

  typedef struct packed {
    logic [63:0] data;
    logic        sop;
    logic        eop;
    logic [2:0]  empty;
    logic        err;
  } beat_t;

  beat_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int rdy_mode = 2;
  int cyc = 0;

  always #4 clk = ~clk;

  gapless_tx_feeder i_gapless_tx_feeder (
    .clk(clk), .rst_n(rst_n), .cfg_rdy_late(cfg_rdy_late),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_empty(in_empty), .in_err(in_err), .in_data(in_data),
    .out_ready(out_ready),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_empty(out_empty), .out_err(out_err), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] word_val(input int pid, input int w);
    return {16'(pid), 16'(w), 16'hC0DE ^ 16'(pid * 7), 16'(w * 3 + 1)};
  endfunction

  // Sink ready patterns: 0 always high, 1 irregular, 2 held low.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
        default: out_ready = 1'b0;
      endcase
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0; in_empty = '0;
    end
  endtask

  // keep: number of words expected on the output (0 = dropped).
  task automatic send_pkt(input int pid, input int nwords, input int last_bytes,
                          input int keep, input bit err_last, input bit err_mid,
                          input bit quiet_start);
    beat_t b;
    for (int w = 0; w < keep; w++) begin
      b.data  = word_val(pid, w);
      b.sop   = (w == 0);
      b.eop   = (w == keep - 1);
      b.empty = (w == keep - 1 && keep == nwords) ? 3'(8 - last_bytes) : 3'd0;
      b.err   = (w == keep - 1) && ((keep < nwords) || err_last);
      exp_q.push_back(b);
    end
    for (int w = 0; w < nwords; w++) begin
      @(negedge clk);
      if (quiet_start && w > 0)
        check(out_valid == 1'b0, "R1", "valid before end word stored", 64'(out_valid), 64'd0);
      in_valid = 1'b1;
      in_sop   = (w == 0);
      in_eop   = (w == nwords - 1);
      in_empty = (w == nwords - 1) ? 3'(8 - last_bytes) : 3'(w + 1);
      in_err   = (w == nwords - 1) ? err_last : err_mid;
      in_data  = word_val(pid, w);
    end
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == n - 1); in_err = 1'b1;
      in_empty = 3'd5; in_data = 64'hDEAD_BEEF_0000_0000 | 64'(i);
    end
  endtask

  task automatic wait_drain(input string req);
    int t;
    t = 0;
    while ((exp_q.size() != 0 || out_valid) && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, req, "words still expected after drain", 64'(exp_q.size()), 64'd0);
    check(out_valid == 1'b0, req, "valid after drain", 64'(out_valid), 64'd0);
  endtask

  // Monitor: predicts takes from its own ready history and pops the scoreboard.
  initial begin
    beat_t       e;
    bit          take, in_pkt, pv, ptake, h1, h2, h3;
    logic [63:0] pdata;
    in_pkt = 0; pv = 0; ptake = 0; h1 = 0; h2 = 0; h3 = 0; pdata = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #2;
      take = out_valid && (cfg_rdy_late ? h3 : out_ready);
      if (in_pkt && !out_valid)
        check(1'b0, "R1", "valid dropped inside packet", 64'd0, 64'd1);
      if (pv && !ptake && out_valid)
        check(out_data == pdata, "R3", "word changed while not taken", out_data, pdata);
      if (take) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "unexpected output word", out_data, 64'd0);
        end else begin
          e = exp_q.pop_front();
          check(out_data == e.data, "R2", "data", out_data, e.data);
          check({out_sop, out_eop} == {e.sop, e.eop}, "R1", "start/end marks",
                64'({out_sop, out_eop}), 64'({e.sop, e.eop}));
          check(out_empty == e.empty, "R5", "empty count", 64'(out_empty), 64'(e.empty));
          check(out_err == e.err, "R6", "error flag", 64'(out_err), 64'(e.err));
        end
        if (out_sop) in_pkt = 1;
        if (out_eop) in_pkt = 0;
      end
      pv = out_valid; ptake = take; pdata = out_data;
      h3 = h2; h2 = h1; h1 = out_ready;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    check({out_valid, out_sop, out_eop} == 3'b000, "R10", "outputs in reset",
          64'({out_valid, out_sop, out_eop}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid after reset", 64'(out_valid), 64'd0);

    // Same-cycle mode, sink always ready
    rdy_mode = 0;
    send_pkt(1, 3, 5, 3, 0, 1, 1);   // mid-word error ignored (R6)
    idle(3);
    send_pkt(2, 2, 1, 2, 1, 0, 0);   // nine bytes, error at end
    send_pkt(3, 1, 8, 0, 0, 0, 0);   // single word: dropped (R4)
    send_pkt(4, 5, 8, 5, 0, 0, 0);
    idle(2);
    wait_drain("R4");
    stray(3);                         // outside any packet (R9)
    idle(2);
    send_pkt(5, 4, 3, 4, 0, 0, 1);
    idle(2);
    wait_drain("R9");

    // Same-cycle mode, irregular ready
    rdy_mode = 1;
    for (int p = 0; p < 8; p++) begin
      send_pkt(10 + p, 2 + (p % 4), 1 + p, 2 + (p % 4), p[0], 1, 0);
      idle(12);
    end
    wait_drain("R3");

    // Delayed-ready mode, changed while idle
    cfg_rdy_late = 1'b1;
    for (int p = 0; p < 8; p++) begin
      send_pkt(30 + p, 2 + (p % 3), 8 - p, 2 + (p % 3), ~p[0], 0, 0);
      idle(14);
    end
    wait_drain("R3");
    rdy_mode = 0;
    send_pkt(40, 6, 2, 6, 0, 1, 0);
    send_pkt(41, 2, 7, 2, 1, 0, 0);
    idle(2);
    wait_drain("R3");

    // Overflow with a stalled sink, same-cycle mode
    cfg_rdy_late = 1'b0;
    rdy_mode = 2;
    idle(4);
    send_pkt(50, 14, 6, 14, 0, 0, 0);  // fill reaches 14
    send_pkt(51, 5, 3, 2, 0, 0, 0);    // cut after 2 words (R8)
    send_pkt(52, 2, 4, 0, 0, 0, 0);    // no room for a start (R7)
    idle(6);
    check(out_valid == 1'b1 && out_sop == 1'b1, "R3", "held start while stalled",
          64'({out_valid, out_sop}), 64'd3);
    rdy_mode = 0;
    wait_drain("R8");

    rdy_mode = 2;
    idle(4);
    send_pkt(60, 15, 4, 15, 0, 0, 0);  // fill reaches 15
    send_pkt(61, 3, 8, 0, 0, 0, 0);    // one free entry: dropped (R7)
    idle(4);
    rdy_mode = 0;
    wait_drain("R7");
    send_pkt(62, 3, 2, 3, 0, 0, 0);    // recovery after drops
    idle(2);
    wait_drain("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule